// File: doc/BRIEF.md
# UART Bit-Rate Strobe Selector

This block produces the one-cycle bit-rate strobe that paces a UART's shifter. It has three possible sources. The first is a fixed division of the core clock. The second is a divided count of pulses from an external timer overflow. The third is an independent 16-bit programmable divider that runs directly on the core clock. The serial mode, a double-rate bit and a source-select bit pick which source drives the strobe, and they also set the divide ratio.

Software sets up the block through a byte-wide write port. That port reaches three registers: the low rate byte, the high rate byte and a control byte. The control byte holds the generator enable and the source select. The rate bytes are locked while the generator is enabled. This keeps a half-written rate value out of the divider. Whenever the mode, double-rate or source selection changes, the fixed and timer dividers restart. The first strobe under the new setting therefore always comes after a full period.

Top module: `baud_strobe_sel`

## Requirements
- R1: After reset the strobe is low and both rate bytes, the enable bit and the source-select bit are 0. With no timer pulses arriving, modes 1 and 3 then produce no strobe, and enabling the generator gives a period of 16 clocks.
- R2: A write with `wr_sel` = 0 loads the low rate byte and `wr_sel` = 1 loads the high rate byte. `wr_sel` = 2 loads the control byte, where bit 0 is the generator enable and bit 1 is the source select. A write with `wr_sel` = 3 changes nothing.
- R3: The programmable generator gives one strobe every R + 16 core clocks, where R = {high byte, low byte}.
- R4: While disabled, the generator holds its count at zero and gives no strobe. The first strobe comes R + 16 clocks after the clock edge that sets the enable bit.
- R5: A write to either rate byte while the enable bit is 1 is ignored.
- R6: With `ser_mode` = 0, the strobe comes every 16 clocks, whatever the double-rate and source-select bits hold.
- R7: With `ser_mode` = 2, the strobe comes every 32 clocks when `dbl_rate` = 0 and every 16 clocks when `dbl_rate` = 1.
- R8: With `ser_mode` = 1 or 3 and source select 1, the strobe comes from the programmable generator and `dbl_rate` has no effect.
- R9: With `ser_mode` = 1 or 3 and source select 0, the block gives one strobe per 64 timer-overflow pulses when `dbl_rate` = 0, and one per 32 when `dbl_rate` = 1. The strobe appears in the cycle after the clock edge that samples the last pulse.
- R10: A change of `ser_mode`, `dbl_rate` or source select restarts the fixed and timer dividers. The first strobe after the change comes one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 low rate byte, 1 high rate byte, 2 control |
| wr_data | input | 8 | Write data |
| ser_mode | input | 2 | Serial mode number, 0 to 3 |
| dbl_rate | input | 1 | Double-rate bit |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| baud_tick | output | 1 | One-cycle bit-rate strobe |

## Verification
The bench sweeps every combination of mode, double-rate and source select. In each clock-driven setting it measures both the delay from the change to the first strobe and the steady period. This separates the 16 and 32 divisions, and it catches a divider that keeps an old phase instead of restarting. The timer settings are driven with counted overflow pulses. The bench checks that nothing appears one pulse before the 32nd or 64th pulse and that a strobe appears exactly on it. The programmable path is tried with rate values whose high byte is zero and nonzero, including 0. Those runs check the delay from the enable edge, the period, the lock on rate writes while enabled, and a write to the unused select code.

// File: rtl/baud_sel_pkg.sv
// Package: shared register-select codes and the divider configuration type.
package baud_sel_pkg;
    typedef enum logic [1:0] {
        WSEL_RATE_LO = 2'd0,
        WSEL_RATE_HI = 2'd1,
        WSEL_CTRL    = 2'd2,
        WSEL_NONE    = 2'd3
    } wsel_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       dbl;
        logic       src;
    } rate_cfg_t;
endpackage

// File: rtl/baud_rate_regs.sv
// Rate and control registers behind a byte write port.
// Assumes: a rate value is two bytes. A rate byte write is dropped while
// the generator enable is set, so the divider never sees a partial value.
module baud_rate_regs
    import baud_sel_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [2*BYTE_W-1:0] rate_o,
    output logic                gen_en_o,
    output logic                src_sel_o
);
    localparam int RATE_W = 2 * BYTE_W;

    logic [RATE_W-1:0] rate_q;
    logic              gen_en_q;
    logic              src_q;

    // Register update: the rate bytes load only while the generator is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q   <= '0;
            gen_en_q <= 1'b0;
            src_q    <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                WSEL_RATE_LO: if (!gen_en_q) rate_q[BYTE_W-1:0]      <= wr_data;
                WSEL_RATE_HI: if (!gen_en_q) rate_q[RATE_W-1:BYTE_W] <= wr_data;
                WSEL_CTRL: begin
                    gen_en_q <= wr_data[0];
                    src_q    <= wr_data[1];
                end
                default: ;
            endcase
        end
    end

    assign rate_o    = rate_q;
    assign gen_en_o  = gen_en_q;
    assign src_sel_o = src_q;

    // R5
    rate_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en_q && wr_en && wr_sel != WSEL_CTRL) |=> $stable(rate_q));
endmodule

// File: rtl/baud_prog_div.sv
// Programmable divider: one strobe every (rate + OFFSET) clocks.
// Assumes: rate_i is stable while en_i is high. With en_i low, the count
// holds at zero, so counting starts cleanly on the cycle after enable.
module baud_prog_div #(
    parameter int RATE_W = 16,
    parameter int OFFSET = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);
    localparam int CNT_W = RATE_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             tick_q;

    assign last_cnt = {1'b0, rate_i} + CNT_W'(OFFSET - 1);

    // Count clocks while enabled and flag the wrap as a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (cnt_q == last_cnt) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    // R4
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0 && !tick_q));
    // R3
    prog_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
endmodule

// File: rtl/baud_fixed_div.sv
// Event divider shared by the fixed clock divisions and the timer path.
// Counts qualifying events up to term_i and emits a one-cycle strobe.
// Assumes: a change of term_i arrives together with restart_i.
module baud_fixed_div #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             event_i,
    input  logic [CNT_W-1:0] term_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             tick_q;

    // Restart on a configuration change, otherwise count events to the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (event_i && cnt_q == term_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + CNT_W'(event_i);
            tick_q <= 1'b0;
        end
    end

    assign tick_o = tick_q;

    // R10
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (!tick_q && cnt_q == '0));
    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_i |-> cnt_q <= term_i);
endmodule

// File: rtl/baud_strobe_sel.sv
// Top: picks the bit-rate strobe source from the serial mode, the double-rate
// bit and the source-select bit. Modes 0 and 2 divide the core clock. Modes 1
// and 3 use either timer overflows or the programmable generator.
// Assumes: tmr_ovf pulses last one clock and all inputs share clk.
module baud_strobe_sel
    import baud_sel_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int PROG_OFFSET = 16,
    parameter int CLK_DIV_HI  = 16,
    parameter int CLK_DIV_LO  = 32,
    parameter int TMR_DIV_HI  = 32,
    parameter int TMR_DIV_LO  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        ser_mode,
    input  logic              dbl_rate,
    input  logic              tmr_ovf,
    output logic              baud_tick
);
    localparam int RATE_W = 2 * BYTE_W;
    localparam int DIV_W  = $clog2(TMR_DIV_LO);

    logic [RATE_W-1:0] rate;
    logic              gen_en;
    logic              src_sel;
    rate_cfg_t         cfg, cfg_q;
    logic              restart;
    logic              use_prog, use_tmr;
    logic              div_event;
    logic [DIV_W-1:0]  div_term;
    logic              prog_tick, fix_tick;

    baud_rate_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rate_o(rate), .gen_en_o(gen_en), .src_sel_o(src_sel)
    );

    assign cfg      = '{mode: ser_mode, dbl: dbl_rate, src: src_sel};
    assign restart  = (cfg != cfg_q);
    assign use_prog = ser_mode[0] && src_sel;
    assign use_tmr  = ser_mode[0] && !src_sel;

    // Remember the last configuration so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg;
    end

    // Choose the events to count and the terminal count for the shared divider.
    always_comb begin
        if (use_tmr) begin
            div_event = tmr_ovf;
            div_term  = dbl_rate ? DIV_W'(TMR_DIV_HI - 1) : DIV_W'(TMR_DIV_LO - 1);
        end else if (use_prog) begin
            div_event = 1'b0;
            div_term  = DIV_W'(CLK_DIV_HI - 1);
        end else if (ser_mode == 2'd2) begin
            div_event = 1'b1;
            div_term  = dbl_rate ? DIV_W'(CLK_DIV_HI - 1) : DIV_W'(CLK_DIV_LO - 1);
        end else begin
            div_event = 1'b1;
            div_term  = DIV_W'(CLK_DIV_HI - 1);
        end
    end

    baud_fixed_div #(.CNT_W(DIV_W)) u_fixed (
        .clk(clk), .rst_n(rst_n), .restart_i(restart), .event_i(div_event),
        .term_i(div_term), .tick_o(fix_tick)
    );

    baud_prog_div #(.RATE_W(RATE_W), .OFFSET(PROG_OFFSET)) u_prog (
        .clk(clk), .rst_n(rst_n), .en_i(gen_en), .rate_i(rate), .tick_o(prog_tick)
    );

    assign baud_tick = use_prog ? prog_tick : fix_tick;

    // R8
    prog_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (use_prog && baud_tick) |-> gen_en);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !baud_tick);
endmodule

// File: tb/baud_strobe_sel_bench.sv
`timescale 1ns/100ps
module baud_strobe_sel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] ser_mode = 2'd1;
    logic       dbl_rate = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       baud_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    baud_strobe_sel u_baud_strobe_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ser_mode(ser_mode), .dbl_rate(dbl_rate), .tmr_ovf(tmr_ovf), .baud_tick(baud_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "watchdog", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!baud_tick && n < 2000);
    endtask

    task automatic count_ticks(input int cycles, output int t);
        t = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (baud_tick) t++;
        end
    endtask

    task automatic pulses(input int k, inout int t);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            if (baud_tick) t++;
            tmr_ovf = 1'b1;
            @(negedge clk);
            if (baud_tick) t++;
            tmr_ovf = 1'b0;
        end
    endtask

    function automatic int exp_period(input int m, input int d, input int s);
        if (m == 0) return 16;
        if (m == 2) return d ? 16 : 32;
        return d ? 32 : 64;
    endfunction

    task automatic prog_run(input int r, input string req);
        int n;
        wr(2'd2, 8'h02);
        wr(2'd0, 8'(r));
        wr(2'd1, 8'(r >> 8));
        wr(2'd2, 8'h03);
        wait_tick(n);
        check(n == r + 16, req, n, r + 16);
        wait_tick(n);
        check(n == r + 16, req, n, r + 16);
    endtask

    initial begin
        int n, t, p;
        // R1: strobe held low during reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(baud_tick == 1'b0, "R1", baud_tick, 0);
        end
        rst_n = 1'b1;
        // R1: source select 0 and enable 0 after reset, so no strobe without timer pulses
        count_ticks(200, t);
        check(t == 0, "R1", t, 0);
        // R1: rate bytes cleared, so enabling gives a 16-clock period
        wr(2'd2, 8'h03);
        wait_tick(n);
        check(n == 16, "R1", n, 16);

        // Sweep of mode, double-rate and source select (R6, R7, R9, R10, R4)
        for (int s = 0; s < 2; s++) begin
            wr(2'd2, 8'(s << 1));
            for (int m = 0; m < 4; m++) begin
                for (int d = 0; d < 2; d++) begin
                    @(negedge clk);
                    ser_mode = 2'(m); dbl_rate = 1'(d);
                    p = exp_period(m, d, s);
                    if (m[0] == 1'b0) begin
                        wait_tick(n);
                        check(n == p + 1, (m == 0) ? "R6 R10" : "R7 R10", n, p + 1);
                        wait_tick(n);
                        check(n == p, (m == 0) ? "R6" : "R7", n, p);
                    end else if (s == 0) begin
                        t = 0;
                        pulses(p - 1, t);
                        check(t == 0, "R9 R10", t, 0);
                        pulses(1, t);
                        check(t == 1, "R9", t, 1);
                        pulses(p, t);
                        check(t == 2, "R9", t, 2);
                        count_ticks(100, t);
                        check(t == 0, "R9", t, 0);
                    end else begin
                        count_ticks(300, t);
                        check(t == 0, "R4", t, 0);
                    end
                end
            end
        end

        // Programmable generator periods (R3, R4), including a nonzero high byte (R2)
        @(negedge clk);
        ser_mode = 2'd1; dbl_rate = 1'b0;
        prog_run(0, "R3 R4");
        prog_run(1, "R3 R4");
        prog_run(37, "R3 R4");
        prog_run(300, "R2 R3 R4");

        // R8: double-rate and mode 3 do not change the generator period
        prog_run(5, "R3");
        @(negedge clk);
        dbl_rate = 1'b1;
        wait_tick(n);
        wait_tick(n);
        check(n == 21, "R8", n, 21);
        @(negedge clk);
        ser_mode = 2'd3; dbl_rate = 1'b0;
        wait_tick(n);
        wait_tick(n);
        check(n == 21, "R8", n, 21);

        // R5: rate byte writes are dropped while enabled
        wr(2'd0, 8'd100);
        wr(2'd1, 8'd2);
        wait_tick(n);
        wait_tick(n);
        check(n == 21, "R5", n, 21);
        wr(2'd2, 8'h02);
        wr(2'd0, 8'd100);
        wr(2'd2, 8'h03);
        wait_tick(n);
        check(n == 116, "R5", n, 116);

        // R2: select code 3 changes nothing (generator stays disabled)
        wr(2'd2, 8'h02);
        wr(2'd3, 8'h03);
        count_ticks(300, t);
        check(t == 0, "R2", t, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule